// File: doc/BRIEF.md
# Vector Page Remap Decoder

This block is an address translation stage placed in front of a fetch path. An access that falls in the 512-byte window at address zero goes to a page chosen by software. The new address is the 21-bit page number placed above the low nine offset bits of the incoming address. Every other address passes through unchanged. The block also reports whether each access goes to flash or to SRAM. Inside the window, the two top page bits decide this. Outside it, the normal memory map decides.

A remap command loads the page register. A command that carries an illegal page number is refused: the block raises an error pulse for one cycle and keeps the previous page. The page resets to zero, so out of reset the window maps onto the start of flash. The current page can be read back, placed in a status word. Each translation is registered and appears one cycle after its request, together with a valid flag.

Top module: `vec_remap_xlate`

## Requirements
- R1: Out of reset `out_valid` and `cmd_err` are 0 and `page_status` is 0. A request to an address in the window then yields the same address, with `out_sram` = 0 (flash).
- R2: A request with `req_addr` below 0x200 yields `out_addr` = {2'b00, page[20:0], req_addr[8:0]}.
- R3: A request with `req_addr` of 0x200 or above yields `out_addr` = `req_addr`.
- R4: For a request inside the window, `out_sram` is 0 when page bits [20:19] are 00 and 1 when they are 10.
- R5: For a request outside the window, `out_sram` is 1 exactly when `req_addr[31:28]` = 4'h2.
- R6: A command with `cmd_code` = 7'h2E and a legal page loads that page. From the next cycle `page_status[29:9]` holds the page and all other bits of `page_status` are 0. A page is legal when bits [18:12] are zero and bits [20:19] are 00 or 10.
- R7: A 7'h2E command with an illegal page sets `cmd_err` to 1 for exactly the following cycle and leaves the page unchanged.
- R8: A command with any code other than 7'h2E changes neither the page nor `cmd_err`.
- R9: `out_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 after a cycle with `req_valid` = 0.
- R10: A request presented in the same cycle as a page-loading command is translated with the page held before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 7 | Command code; 7'h2E requests a remap |
| cmd_page | input | 21 | Page number carried by the command |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 32 | Incoming byte address |
| out_valid | output | 1 | Translated address valid, one cycle after request |
| out_addr | output | 32 | Translated address |
| out_sram | output | 1 | Target select: 1 = SRAM, 0 = flash |
| cmd_err | output | 1 | One-cycle pulse on a refused remap |
| page_status | output | 32 | Current page in bits [29:9], other bits zero |

## Verification
A page load and a translation can happen in the same cycle. In that case the request must use the page held before the load. The bench provokes this by driving a remap command and a window request on the same clock edge. It checks that the returned address carries the old page, and that the next request to the same address carries the new page. A refused command in the same style must leave both translations on the old page.

// File: rtl/vremap_pkg.sv
package vremap_pkg;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_SRAM  = 1'b1
    } target_e;

    localparam logic [6:0] REMAP_CMD_DEFAULT = 7'h2E;

endpackage

// File: rtl/remap_page_reg.sv
module remap_page_reg #(
    parameter int PAGE_W     = 21,
    parameter int CMD_W      = 7,
    parameter int RSVD_LO    = 12,
    parameter logic [CMD_W-1:0] REMAP_CODE = 7'h2E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [PAGE_W-1:0] cmd_page,
    output logic [PAGE_W-1:0] page_q,
    output logic              err_q
);
    localparam int RSVD_HI = PAGE_W - 3;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              err;
    } state_t;

    state_t st_d, st_q;
    logic   hit, legal;

    always_comb begin
        hit   = cmd_valid && (cmd_code == REMAP_CODE);
        legal = (cmd_page[RSVD_HI:RSVD_LO] == '0) && !cmd_page[PAGE_W-2];
        st_d      = st_q;
        st_d.err  = hit && !legal;
        if (hit && legal) begin
            st_d.page = cmd_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_q = st_q.page;
    assign err_q  = st_q.err;

    AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.page[RSVD_HI:RSVD_LO] == '0) && !st_q.page[PAGE_W-2]); // R6

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(page_q)); // R7

endmodule

// File: rtl/remap_window.sv
module remap_window #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 9,
    parameter int PAGE_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic              in_win,
    output logic [ADDR_W-1:0] xaddr
);
    localparam int PAD_W = ADDR_W - PAGE_W - OFS_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                in_win = (addr[ADDR_W-1:OFS_W] == '0);
                xaddr  = in_win ? {{PAD_W{1'b0}}, page, addr[OFS_W-1:0]} : addr;
            end
        end else begin : g_nopad
            always_comb begin
                in_win = (addr[ADDR_W-1:OFS_W] == '0);
                xaddr  = in_win ? ADDR_W'({page, addr[OFS_W-1:0]}) : addr;
            end
        end
    endgenerate

endmodule

// File: rtl/remap_target.sv
module remap_target
    import vremap_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter logic [TAG_W-1:0] SRAM_TAG = 4'h2
) (
    input  logic             in_win,
    input  logic [1:0]       page_sel,
    input  logic [TAG_W-1:0] addr_tag,
    output target_e          tgt
);
    always_comb begin
        if (in_win) begin
            tgt = (page_sel == 2'b10) ? TGT_SRAM : TGT_FLASH;
        end else begin
            tgt = (addr_tag == SRAM_TAG) ? TGT_SRAM : TGT_FLASH;
        end
    end

endmodule

// File: rtl/vec_remap_xlate.sv
module vec_remap_xlate
    import vremap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 9,
    parameter int PAGE_W  = 21,
    parameter int CMD_W   = 7,
    parameter int RSVD_LO = 12,
    parameter int TAG_W   = 4,
    parameter logic [TAG_W-1:0] SRAM_TAG   = 4'h2,
    parameter logic [CMD_W-1:0] REMAP_CODE = REMAP_CMD_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_sram,
    output logic              cmd_err,
    output logic [ADDR_W-1:0] page_status
);
    localparam int STAT_PAD = ADDR_W - PAGE_W - OFS_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              sram;
    } out_t;

    logic [PAGE_W-1:0] page_q;
    logic              in_win;
    logic [ADDR_W-1:0] xaddr;
    target_e           tgt;
    out_t              o_d, o_q;

    remap_page_reg #(
        .PAGE_W(PAGE_W), .CMD_W(CMD_W), .RSVD_LO(RSVD_LO), .REMAP_CODE(REMAP_CODE)
    ) u_page (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_page(cmd_page), .page_q(page_q), .err_q(cmd_err)
    );

    remap_window #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W)
    ) u_win (
        .addr(req_addr), .page(page_q), .in_win(in_win), .xaddr(xaddr)
    );

    remap_target #(
        .TAG_W(TAG_W), .SRAM_TAG(SRAM_TAG)
    ) u_tgt (
        .in_win(in_win), .page_sel(page_q[PAGE_W-1:PAGE_W-2]),
        .addr_tag(req_addr[ADDR_W-1:ADDR_W-TAG_W]), .tgt(tgt)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = req_valid;
        if (req_valid) begin
            o_d.addr = xaddr;
            o_d.sram = (tgt == TGT_SRAM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid   = o_q.vld;
    assign out_addr    = o_q.addr;
    assign out_sram    = o_q.sram;
    assign page_status = {{STAT_PAD{1'b0}}, page_q, {OFS_W{1'b0}}};

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R9

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[ADDR_W-1:OFS_W] != '0)) |=> (out_addr == $past(req_addr))); // R3

    AST_WIN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[ADDR_W-1:OFS_W] == '0)) |=> (out_sram == $past(page_q[PAGE_W-1]))); // R4

    AST_WIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[ADDR_W-1:OFS_W] == '0))
            |=> (out_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]))); // R2

endmodule

// File: tb/sim_vec_remap_xlate.sv
module sim_vec_remap_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [6:0]  cmd_code = '0;
    logic [20:0] cmd_page = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid, out_sram, cmd_err;
    logic [31:0] out_addr, page_status;

    int checks = 0;
    int errors = 0;
    logic [20:0] cur_page = '0;

    always #10 clk = ~clk;

    vec_remap_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_page(cmd_page), .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_sram(out_sram),
        .cmd_err(cmd_err), .page_status(page_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [20:0] p);
        return (a < 32'h200) ? {2'b00, p, a[8:0]} : a;
    endfunction

    function automatic logic exp_sram(input logic [31:0] a, input logic [20:0] p);
        return (a < 32'h200) ? p[20] : (a[31:28] == 4'h2);
    endfunction

    function automatic logic page_legal(input logic [20:0] p);
        return (p[18:12] == 7'd0) && !p[19];
    endfunction

    task automatic xlate(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " addr"}, out_addr, exp_addr(a, cur_page));
        chk({tag, " target"}, {31'd0, out_sram}, {31'd0, exp_sram(a, cur_page)});
    endtask

    task automatic cmd(input logic [6:0] code, input logic [20:0] p);
        logic expect_err;
        expect_err = (code == 7'h2E) && !page_legal(p);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_page  = p;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (code == 7'h2E && page_legal(p)) cur_page = p;
        chk(code == 7'h2E ? "R7 err flag" : "R8 err flag", {31'd0, cmd_err}, {31'd0, expect_err});
        chk(code == 7'h2E ? "R6 status" : "R8 status", page_status, {2'b00, cur_page, 9'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 err", {31'd0, cmd_err}, 32'd0);
        chk("R1 status", page_status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
        xlate(32'h0000_01C0, "R1 reset window");
        xlate(32'h0000_0000, "R1 reset zero");

        // R2 R4: full offset sweep under several legal pages
        for (int k = 0; k < 4; k++) begin
            logic [20:0] p;
            case (k)
                0: p = 21'h0_0FFF;
                1: p = 21'h10_0000;
                2: p = 21'h10_0ABC;
                default: p = 21'h0_0001;
            endcase
            cmd(7'h2E, p);
            for (int o = 0; o < 512; o++) xlate(32'(o), "R2 R4 window");
        end

        // R3 R5: pass-through, walking ones and region edges
        for (int b = 9; b < 32; b++) xlate(32'h1 << b, "R3 R5 walk");
        xlate(32'h0000_0200, "R3 edge");
        xlate(32'hFFFF_FFFF, "R3 R5 top");
        xlate(32'h2000_0000, "R5 sram low");
        xlate(32'h2FFF_FFFF, "R5 sram high");
        xlate(32'h1FFF_FFFF, "R5 below sram");
        xlate(32'h3000_0000, "R5 above sram");

        // R7: every illegal field pattern
        cmd(7'h2E, 21'h10_0123);
        for (int b = 12; b < 19; b++) begin
            cmd(7'h2E, (21'h1 << b) | 21'h00_0055);
            @(negedge clk);
            chk("R7 pulse ends", {31'd0, cmd_err}, 32'd0);
            xlate(32'h0000_0044, "R7 page kept");
        end
        cmd(7'h2E, 21'h08_0000);
        cmd(7'h2E, 21'h18_0007);
        xlate(32'h0000_01FF, "R7 page kept sel");

        // R8: every other code ignored
        for (int c = 0; c < 128; c++) begin
            if (c != 'h2E) cmd(7'(c), 21'h00_0333);
        end
        xlate(32'h0000_0010, "R8 page kept");

        // R10: load and request in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 7'h2E; cmd_page = 21'h00_0777;
        req_valid = 1'b1; req_addr = 32'h0000_0040;
        @(negedge clk);
        cmd_valid = 1'b0; req_valid = 1'b0;
        chk("R10 old page", out_addr, exp_addr(32'h40, cur_page));
        chk("R10 old target", {31'd0, out_sram}, {31'd0, exp_sram(32'h40, cur_page)});
        cur_page = 21'h00_0777;
        xlate(32'h0000_0040, "R10 new page");

        // R10: refused load and request in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 7'h2E; cmd_page = 21'h18_0000;
        req_valid = 1'b1; req_addr = 32'h0000_0100;
        @(negedge clk);
        cmd_valid = 1'b0; req_valid = 1'b0;
        chk("R10 R7 refused err", {31'd0, cmd_err}, 32'd1);
        chk("R10 refused addr", out_addr, exp_addr(32'h100, cur_page));
        xlate(32'h0000_0100, "R10 refused after");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule